// File: doc/BRIEF.md
# Dual-Loop Synthesizer Divider and Phase Detector Core

This block holds the digital half of a frequency synthesizer that runs two phase-locked loops, one for transmit and one for receive, from a single crystal. A programmable reference divider turns crystal events into a base reference pulse train. A post-divider chain derives two slower rates from it: one four times slower, and one a further twenty-five times slower. A two-bit code then picks which of the three rates each loop compares against.

Each loop has its own programmable feedback divider, stepped by that loop's oscillator. A phase-frequency detector compares the divided oscillator with the chosen reference. The detector drives a pump pair: one flag asks the external charge pump to source current, the other asks it to sink current, and with both flags low the pump output floats. A lock detector watches the transmit detector and reports lock on an active-low flag.

All logic runs on one fast sampling clock. The crystal and the two oscillators reach the block as one-cycle event strobes on that clock. Divide ratios and the select code can be changed at any time. A changed ratio is picked up at the divider's next terminal count, so no short cycle is ever produced.

Top module: `synth_core`

## Requirements
- R1: While reset is asserted and after its release, tx_up, tx_dn, rx_up and rx_dn are 0 and tx_lock_n is 1. Every divider restarts so that its first enabled event after reset is a terminal count.
- R2: The reference divider emits one base-rate pulse every ref_div crystal events. The first pulse comes on the first crystal event after reset. A ref_div below 16 acts as 16.
- R3: Each feedback divider emits one pulse every tx_div (or rx_div) oscillator events. The first pulse comes on the first oscillator event after reset. A ratio below 16 acts as 16.
- R4: The medium rate pulses on every 4th base pulse, starting with the 4th. The slow rate pulses on every 25th medium pulse, starting with the 25th. Every selected reference pulse coincides with a base pulse.
- R5: ref_sel is {bit1, bit0}, and the reference each loop uses depends on it:
  - 2'b00: transmit base, receive base.
  - 2'b01: transmit medium, receive medium.
  - 2'b10: transmit medium, receive slow.
  - 2'b11: transmit slow, receive medium.
- R6: A reference pulse that arrives alone raises the loop's up flag (drive-high) on the next edge. A lone feedback pulse raises the dn flag (drive-low). The flag falls on the edge that registers the opposite pulse. Coincident pulses raise neither flag. up and dn are never both 1, and up is never followed directly by dn.
- R7: A new feedback ratio is loaded only at the divider's next terminal count. The count already in progress ends at the old ratio.
- R8: tx_lock_n falls one edge after the 8th transmit reference pulse that follows reset or the last over-wide pump pulse. It falls only on an edge that registered a transmit reference pulse.
- R9: If tx_up or tx_dn is seen high on more than LOCK_WIN (default 4) consecutive edges, tx_lock_n is 1 from the next edge, and the count of good reference pulses restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_en | input | 1 | One-cycle strobe per crystal event |
| tx_osc_en | input | 1 | One-cycle strobe per transmit oscillator event |
| rx_osc_en | input | 1 | One-cycle strobe per receive oscillator event |
| ref_div | input | 12 | Reference divide ratio (16 to 4095) |
| tx_div | input | 14 | Transmit feedback ratio (16 to 16383) |
| rx_div | input | 14 | Receive feedback ratio (16 to 16383) |
| ref_sel | input | 2 | Reference routing code |
| tx_up | output | 1 | Transmit pump drive-high request |
| tx_dn | output | 1 | Transmit pump drive-low request |
| rx_up | output | 1 | Receive pump drive-high request |
| rx_dn | output | 1 | Receive pump drive-low request |
| tx_lock_n | output | 1 | Low while the transmit loop is locked |

## Verification
Cycles are counted from the first edge after reset release. A divider pulse is combinational on the edge of its strobe, so a pump flag caused by that pulse is visible after that same edge. The flag clears after the edge that registers the opposite pulse. tx_lock_n changes one edge after the 8th good transmit reference pulse, or one edge after a pump flag has been seen high for LOCK_WIN+1 edges. Every expected value is queued with the exact cycle index worked out from these rules. The monitor compares it in the low phase of that cycle, and treats an item it passed without sampling as a failure.

// File: rtl/synth_pkg.sv
package synth_pkg;

    // Reference routing code {bit1, bit0}
    typedef enum logic [1:0] {
        SEL_BASE_BASE = 2'b00,
        SEL_MED_MED   = 2'b01,
        SEL_MED_SLOW  = 2'b10,
        SEL_SLOW_MED  = 2'b11
    } ref_route_e;

    localparam int MIN_RATIO = 16;

endpackage

// File: rtl/ratio_counter.sv
module ratio_counter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] ratio,
    output logic         term
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic [W-1:0] ratio_eff;

    always_comb begin
        ratio_eff = (ratio < W'(synth_pkg::MIN_RATIO)) ? W'(synth_pkg::MIN_RATIO) : ratio;
        term      = step && (st_q.cnt == '0);
        st_d      = st_q;
        if (step) begin
            st_d.cnt = term ? (ratio_eff - W'(1)) : (st_q.cnt - W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rate_router.sv
module rate_router #(
    parameter int MED_RATIO  = 4,
    parameter int SLOW_RATIO = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_p,
    input  logic [1:0] route,
    output logic       tx_ref,
    output logic       rx_ref
);
    import synth_pkg::*;

    localparam int MW = (MED_RATIO  > 1) ? $clog2(MED_RATIO)  : 1;
    localparam int SW = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;

    typedef struct packed {
        logic [MW-1:0] med_cnt;
        logic [SW-1:0] slow_cnt;
    } state_t;

    state_t st_d, st_q;
    logic   med_p, slow_p;

    always_comb begin
        med_p  = base_p && (st_q.med_cnt == MW'(MED_RATIO - 1));
        slow_p = med_p && (st_q.slow_cnt == SW'(SLOW_RATIO - 1));
        st_d   = st_q;
        if (base_p) begin
            st_d.med_cnt = med_p ? '0 : st_q.med_cnt + MW'(1);
        end
        if (med_p) begin
            st_d.slow_cnt = slow_p ? '0 : st_q.slow_cnt + SW'(1);
        end
        unique case (ref_route_e'(route))
            SEL_BASE_BASE: begin tx_ref = base_p; rx_ref = base_p; end
            SEL_MED_MED:   begin tx_ref = med_p;  rx_ref = med_p;  end
            SEL_MED_SLOW:  begin tx_ref = med_p;  rx_ref = slow_p; end
            default:       begin tx_ref = slow_p; rx_ref = med_p;  end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/phase_cmp.sv
module phase_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_p,
    input  logic fb_p,
    output logic up,
    output logic dn
);
    typedef struct packed {
        logic up;
        logic dn;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d.up = st_q.up | ref_p;
        st_d.dn = st_q.dn | fb_p;
        if (st_d.up && st_d.dn) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign up = st_q.up;
    assign dn = st_q.dn;
endmodule

// File: rtl/lock_watch.sv
module lock_watch #(
    parameter int WIN  = 4,
    parameter int REFS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_p,
    input  logic up,
    input  logic dn,
    output logic locked
);
    localparam int WW = $clog2(WIN + 1);
    localparam int GW = $clog2(REFS + 1);

    typedef struct packed {
        logic [WW-1:0] width;
        logic [GW-1:0] good;
        logic          lock;
    } state_t;

    state_t st_d, st_q;
    logic   active, wide;

    always_comb begin
        active = up | dn;
        wide   = active && (st_q.width == WW'(WIN));
        st_d   = st_q;
        if (!active) begin
            st_d.width = '0;
        end else if (!wide) begin
            st_d.width = st_q.width + WW'(1);
        end
        if (wide) begin
            st_d.good = '0;
            st_d.lock = 1'b0;
        end else begin
            if (ref_p && (st_q.good != GW'(REFS))) begin
                st_d.good = st_q.good + GW'(1);
            end
            st_d.lock = st_q.lock | (st_d.good == GW'(REFS));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.lock;
endmodule

// File: rtl/synth_core.sv
module synth_core #(
    parameter int REF_W      = 12,
    parameter int FB_W       = 14,
    parameter int MED_RATIO  = 4,
    parameter int SLOW_RATIO = 25,
    parameter int LOCK_WIN   = 4,
    parameter int LOCK_REFS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_en,
    input  logic             tx_osc_en,
    input  logic             rx_osc_en,
    input  logic [REF_W-1:0] ref_div,
    input  logic [FB_W-1:0]  tx_div,
    input  logic [FB_W-1:0]  rx_div,
    input  logic [1:0]       ref_sel,
    output logic             tx_up,
    output logic             tx_dn,
    output logic             rx_up,
    output logic             rx_dn,
    output logic             tx_lock_n
);
    localparam int NLOOP = 2;  // index 0 transmit, index 1 receive

    logic             ref_a, tx_ref, rx_ref, tx_locked;
    logic [NLOOP-1:0] loop_step, loop_ref, loop_fb, loop_up, loop_dn;
    logic [FB_W-1:0]  loop_ratio [NLOOP];

    ratio_counter #(.W(REF_W)) u_refdiv (
        .clk(clk), .rst_n(rst_n), .step(xtal_en), .ratio(ref_div), .term(ref_a)
    );

    rate_router #(.MED_RATIO(MED_RATIO), .SLOW_RATIO(SLOW_RATIO)) u_route (
        .clk(clk), .rst_n(rst_n), .base_p(ref_a), .route(ref_sel),
        .tx_ref(tx_ref), .rx_ref(rx_ref)
    );

    assign loop_step     = {rx_osc_en, tx_osc_en};
    assign loop_ref      = {rx_ref, tx_ref};
    assign loop_ratio[0] = tx_div;
    assign loop_ratio[1] = rx_div;

    for (genvar i = 0; i < NLOOP; i++) begin : g_loop
        ratio_counter #(.W(FB_W)) u_fbdiv (
            .clk(clk), .rst_n(rst_n), .step(loop_step[i]),
            .ratio(loop_ratio[i]), .term(loop_fb[i])
        );
        phase_cmp u_pfd (
            .clk(clk), .rst_n(rst_n), .ref_p(loop_ref[i]), .fb_p(loop_fb[i]),
            .up(loop_up[i]), .dn(loop_dn[i])
        );
    end

    lock_watch #(.WIN(LOCK_WIN), .REFS(LOCK_REFS)) u_lock (
        .clk(clk), .rst_n(rst_n), .ref_p(tx_ref),
        .up(loop_up[0]), .dn(loop_dn[0]), .locked(tx_locked)
    );

    assign tx_up     = loop_up[0];
    assign tx_dn     = loop_dn[0];
    assign rx_up     = loop_up[1];
    assign rx_dn     = loop_dn[1];
    assign tx_lock_n = ~tx_locked;
endmodule

// File: rtl/synth_core_chk.sv
module synth_core_chk #(
    parameter int LOCK_WIN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ref_a,
    input logic tx_ref,
    input logic rx_ref,
    input logic tx_up,
    input logic tx_dn,
    input logic rx_up,
    input logic rx_dn,
    input logic tx_lock_n
);
    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (tx_up || tx_dn) begin
            run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
        end else begin
            run_q <= '0;
        end
    end

    AST_TX_PUMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(tx_up && tx_dn)); // R6
    AST_RX_PUMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rx_up && rx_dn)); // R6
    AST_TX_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n) tx_up |=> !tx_dn); // R6
    AST_TX_REF_ON_BASE: assert property (@(posedge clk) disable iff (!rst_n) tx_ref |-> ref_a); // R4
    AST_RX_REF_ON_BASE: assert property (@(posedge clk) disable iff (!rst_n) rx_ref |-> ref_a); // R4
    AST_WIDE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_up || tx_dn) && (run_q >= 8'(LOCK_WIN))) |=> tx_lock_n); // R9
    AST_LOCK_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_lock_n) |-> $past(tx_ref)); // R8
endmodule

bind synth_core synth_core_chk #(.LOCK_WIN(LOCK_WIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .tx_ref(tx_ref), .rx_ref(rx_ref),
    .tx_up(tx_up), .tx_dn(tx_dn), .rx_up(rx_up), .rx_dn(rx_dn), .tx_lock_n(tx_lock_n)
);

// File: tb/tb_synth_core.sv
module tb_synth_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_en = 1'b0, tx_osc_en = 1'b0, rx_osc_en = 1'b0;
    logic [11:0] ref_div = 12'd16;
    logic [13:0] tx_div = 14'd16, rx_div = 14'd16;
    logic [1:0]  ref_sel = 2'b00;
    logic        tx_up, tx_dn, rx_up, rx_dn, tx_lock_n;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int wd = 0;
    bit done = 1'b0;

    localparam int SIG_TXUP = 0, SIG_TXDN = 1, SIG_RXUP = 2, SIG_RXDN = 3, SIG_LOCK = 4;

    typedef struct {
        int    cyc;
        int    sig;
        bit    val;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;  // 200 MHz

    synth_core dut (
        .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .tx_osc_en(tx_osc_en),
        .rx_osc_en(rx_osc_en), .ref_div(ref_div), .tx_div(tx_div), .rx_div(rx_div),
        .ref_sel(ref_sel), .tx_up(tx_up), .tx_dn(tx_dn), .rx_up(rx_up), .rx_dn(rx_dn),
        .tx_lock_n(tx_lock_n)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic bit pick(int s);
        case (s)
            SIG_TXUP: return tx_up;
            SIG_TXDN: return tx_dn;
            SIG_RXUP: return rx_up;
            SIG_RXDN: return rx_dn;
            default:  return tx_lock_n;
        endcase
    endfunction

    // driver side: queue an expectation in cycle order
    task automatic expect_at(int c, int s, bit v, string tag);
        exp_t it;
        int pos;
        it.cyc = c; it.sig = s; it.val = v; it.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].cyc > c) begin
                pos = i;
                break;
            end
        end
        sb.insert(pos, it);
    endtask

    // monitor side: compare in the low phase of each cycle
    always @(negedge clk) begin
        if (rst_n) begin
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                exp_t it;
                it = sb.pop_front();
                checks++;
                if (it.cyc < cyc) begin
                    errors++;
                    $display("FAIL %s: item for cycle %0d missed (now %0d) expected %0d",
                             it.tag, it.cyc, cyc, it.val);
                end else if (pick(it.sig) !== it.val) begin
                    errors++;
                    $display("FAIL %s: cycle %0d signal %0d actual %0d expected %0d",
                             it.tag, cyc, it.sig, pick(it.sig), it.val);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic direct_check(bit act, bit exp_v, string tag);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic route_case(logic [1:0] code, int tx_first, int rx_first, string tag);
        ref_div = 12'd16; ref_sel = code;
        xtal_en = 1'b1; tx_osc_en = 1'b0; rx_osc_en = 1'b0;
        do_reset();
        if (tx_first > 1) expect_at(tx_first - 1, SIG_TXUP, 1'b0, tag);
        expect_at(tx_first, SIG_TXUP, 1'b1, tag);
        if (rx_first > 1) expect_at(rx_first - 1, SIG_RXUP, 1'b0, tag);
        expect_at(rx_first, SIG_RXUP, 1'b1, tag);
        run_until(((tx_first > rx_first) ? tx_first : rx_first) + 2);
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        direct_check(tx_up, 1'b0, "R1 tx_up in reset");
        direct_check(tx_dn, 1'b0, "R1 tx_dn in reset");
        direct_check(rx_up | rx_dn, 1'b0, "R1 rx pump in reset");
        direct_check(tx_lock_n, 1'b1, "R1 lock flag in reset");

        // Clamped ratios, lock acquisition, deferred ratio change, lock loss
        ref_div = 12'd3; tx_div = 14'd5; rx_div = 14'd16; ref_sel = 2'b00;
        xtal_en = 1'b1; tx_osc_en = 1'b1; rx_osc_en = 1'b1;
        do_reset();
        expect_at(1,   SIG_TXUP, 1'b0, "R1 first events coincide");
        expect_at(6,   SIG_TXDN, 1'b0, "R3 tx ratio 5 acts as 16");
        expect_at(17,  SIG_TXDN, 1'b0, "R3 clamped feedback period");
        expect_at(17,  SIG_TXUP, 1'b0, "R2 ref ratio 3 acts as 16");
        expect_at(17,  SIG_RXUP, 1'b0, "R6 coincident pulses raise nothing");
        expect_at(112, SIG_LOCK, 1'b1, "R8 not locked before 8th ref");
        expect_at(113, SIG_LOCK, 1'b0, "R8 locked at 8th ref");
        expect_at(129, SIG_TXUP, 1'b0, "R7 old ratio finishes");
        expect_at(129, SIG_TXDN, 1'b0, "R7 old ratio finishes");
        expect_at(144, SIG_TXUP, 1'b0, "R7 before new ratio shows");
        expect_at(145, SIG_TXUP, 1'b1, "R7 new ratio after terminal");
        expect_at(149, SIG_LOCK, 1'b0, "R9 lock kept within window");
        expect_at(150, SIG_LOCK, 1'b1, "R9 wide pulse drops lock");
        expect_at(152, SIG_TXUP, 1'b1, "R6 up held until feedback");
        expect_at(153, SIG_TXUP, 1'b0, "R6 up cleared by feedback");
        run_until(120);
        tx_div = 14'd24;
        run_until(156);

        // Faster transmit oscillator gives drive-low
        ref_div = 12'd20; tx_div = 14'd16; rx_div = 14'd16;
        tx_osc_en = 1'b1; rx_osc_en = 1'b0;
        do_reset();
        expect_at(1,  SIG_RXUP, 1'b1, "R5 code 00 receive on base");
        expect_at(17, SIG_TXDN, 1'b1, "R6 lone feedback gives dn");
        expect_at(17, SIG_TXUP, 1'b0, "R6 no up on lead");
        expect_at(20, SIG_TXDN, 1'b1, "R6 dn held");
        expect_at(21, SIG_TXDN, 1'b0, "R6 dn cleared by reference");
        expect_at(21, SIG_TXUP, 1'b0, "R6 no up after clear");
        run_until(24);

        // Slower receive oscillator gives drive-high; no lock with wide pulses
        ref_div = 12'd16; rx_div = 14'd24;
        tx_osc_en = 1'b0; rx_osc_en = 1'b1;
        do_reset();
        expect_at(17,  SIG_RXUP, 1'b1, "R6 lone reference gives up");
        expect_at(17,  SIG_RXDN, 1'b0, "R6 no dn on lag");
        expect_at(24,  SIG_RXUP, 1'b1, "R6 up held");
        expect_at(25,  SIG_RXUP, 1'b0, "R6 up cleared by feedback");
        expect_at(25,  SIG_RXDN, 1'b0, "R6 no dn after clear");
        expect_at(200, SIG_LOCK, 1'b1, "R9 wide pulses keep unlocked");
        run_until(202);

        // Reference routing and post-divider timing
        route_case(2'b00, 1,    1,    "R5 code 00");
        route_case(2'b01, 49,   49,   "R4 R5 code 01 medium");
        route_case(2'b10, 49,   1585, "R4 R5 code 10 slow rx");
        route_case(2'b11, 1585, 49,   "R4 R5 code 11 slow tx");

        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule